// File: doc/BRIEF.md
# Port-Filtered Fabric Traffic Counter

This block counts host-fabric traffic through a 64-bit register port. Eight traffic sources feed it, one strobe per cycle each, and each strobe carries a 2-bit port tag. Software picks one traffic kind through a control register: read or write on either of two PCIe links, on a coherent link, or on MMIO. A single port filter then sets the whole counter. It either counts that kind across every port or counts only strobes whose tag matches one chosen port.

The count register returns the running total together with an echo of the event code being counted. The echo trails a new selection by one cycle, so software polls until the echo matches before it trusts the total. A separate 64-bit cycle counter runs from power-on reset. Software cannot reset or freeze it.

Top module: `fabric_traffic_counter`

## Requirements
- R1: The control register at address 0x20 reads back exactly the last 64-bit value written to it, and reads 0 after `rst_n`.
- R2: The count register at address 0x28 holds the count in bits 59:0 and the echoed event code in bits 63:60. Event code k (0..7) selects strobe `ev_hit[k]`: 0 PCIe link 0 read, 1 PCIe link 0 write, 2 PCIe link 1 read, 3 PCIe link 1 write, 4 coherent-link read, 5 coherent-link write, 6 MMIO read, 7 MMIO write.
- R3: When control bit 23 (filter enable) is 0, the count rises by exactly one for each cycle in which the selected strobe is high, whatever its port tag.
- R4: When control bit 23 is 1, the count rises only in cycles where the selected strobe is high and `ev_port[k]` equals control bits 21:20.
- R5: Event codes 8..15 in control bits 19:16 never advance the count.
- R6: While control bit 0 is 1, the count reads 0 one cycle later and stays 0, even when bit 8 is also set.
- R7: While control bit 8 is 1 and bit 0 is 0, the count holds its value.
- R8: A control write that changes the event code, the filter enable or the port ID clears the count. A write that leaves all three unchanged does not clear it.
- R9: The echo field shows the newly written event code one cycle after the control write. In the cycle right after the write it still shows the previous code.
- R10: The register at address 0x30 is a 64-bit cycle counter. It rises by one every clock from `rst_n` and wraps to zero on overflow. Control bits 0 and 8 do not affect it.
- R11: A read of any other address returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ev_hit | input | 8 | Per-source event strobes, index = event code |
| ev_port | input | 8x2 | Port tag of each strobe |
| reg_wr | input | 1 | Register write enable |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Register read data, combinational from `reg_addr` |

## Verification
The bench sweeps all eight event codes with filtering off, and with filtering on across every port ID, comparing the totals with counts worked out arithmetically. A decoder that ignored the tag, or compared it with the wrong field, would give totals that are too high. Invalid codes are driven with every strobe held high; a decoder that folded 8..15 onto valid indices would count. Clear is applied while freeze is also set, and writes that repeat the same selection are checked to leave the count alone. The echo is sampled in the cycle after a write, where an echo without a lag would already show the new code. The cycle counter is read across a window in which clear and freeze are held; a design that gated it would show a short interval.

// File: rtl/ftc_pkg.sv
package ftc_pkg;
    localparam int REG_W    = 64;
    localparam int CODE_W   = 4;
    localparam int PORT_W   = 2;
    localparam int ADDR_W   = 8;

    localparam logic [ADDR_W-1:0] ADDR_CTRL  = 8'h20;
    localparam logic [ADDR_W-1:0] ADDR_COUNT = 8'h28;
    localparam logic [ADDR_W-1:0] ADDR_CYCLE = 8'h30;

    localparam int BIT_CLR   = 0;
    localparam int BIT_FRZ   = 8;
    localparam int CODE_LSB  = 16;
    localparam int PID_LSB   = 20;
    localparam int BIT_FILT  = 23;

    typedef struct packed {
        logic              filt;
        logic [PORT_W-1:0] pid;
        logic [CODE_W-1:0] code;
        logic              frz;
        logic              clr;
    } sel_t;

    function automatic sel_t decode_ctrl(input logic [REG_W-1:0] v);
        sel_t s;
        s.filt = v[BIT_FILT];
        s.pid  = v[PID_LSB +: PORT_W];
        s.code = v[CODE_LSB +: CODE_W];
        s.frz  = v[BIT_FRZ];
        s.clr  = v[BIT_CLR];
        return s;
    endfunction
endpackage

// File: rtl/ftc_event_match.sv
module ftc_event_match
    import ftc_pkg::*;
#(
    parameter int NUM_EV = 8
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [NUM_EV-1:0]              ev_hit,
    input  logic [NUM_EV-1:0][PORT_W-1:0]  ev_port,
    input  logic [CODE_W-1:0]              code,
    input  logic                           filt_en,
    input  logic [PORT_W-1:0]              pid,
    output logic                           hit
);
    logic [NUM_EV-1:0] qual;

    generate
        for (genvar g = 0; g < NUM_EV; g++) begin : g_qual
            assign qual[g] = ev_hit[g] && (!filt_en || (ev_port[g] == pid));
        end
    endgenerate

    always_comb begin
        hit = 1'b0;
        for (int j = 0; j < NUM_EV; j++) begin
            if (code == CODE_W'(j)) hit = qual[j];
        end
    end

    // R5: a code outside the event range never produces a hit
    a_r5_invalid_code_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (code >= CODE_W'(NUM_EV)) |-> !hit);
    // R4: with the filter on, a hit implies the selected tag matched
    a_r4_filter_tag_match: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && filt_en && (code < CODE_W'(NUM_EV))) |-> (ev_port[code[2:0]] == pid));
endmodule

// File: rtl/ftc_count_core.sv
module ftc_count_core #(
    parameter int CNT_W = 60
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             frz,
    input  logic             sel_chg,
    input  logic             hit,
    output logic [CNT_W-1:0] cnt
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } core_st_t;

    core_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr || sel_chg) begin
            st_d.cnt = '0;
        end else if (frz) begin
            st_d.cnt = st_q.cnt;
        end else if (hit) begin
            st_d.cnt = st_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt = st_q.cnt;

    // R6: clear forces zero on the next cycle regardless of freeze
    a_r6_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt == '0));
    // R7: freeze without clear or reselection holds the value
    a_r7_freeze_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (frz && !clr && !sel_chg) |=> $stable(cnt));
    // R8: reselection clears the count
    a_r8_reselect_clears: assert property (@(posedge clk) disable iff (!rst_n)
        sel_chg |=> (cnt == '0));
    // R3: otherwise the count moves by at most one per cycle
    a_r3_step_one: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !sel_chg) |=> ((cnt == $past(cnt)) || (cnt == $past(cnt) + CNT_W'(1))));
endmodule

// File: rtl/ftc_cycle_counter.sv
module ftc_cycle_counter #(
    parameter int CLK_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [CLK_W-1:0] cycles
);
    typedef struct packed {
        logic [CLK_W-1:0] cyc;
    } cyc_st_t;

    cyc_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.cyc = st_q.cyc + CLK_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cycles = st_q.cyc;

    // R10: the cycle counter advances by one every clock
    a_r10_cycle_step: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (cycles == $past(cycles) + CLK_W'(1)));
endmodule

// File: rtl/fabric_traffic_counter.sv
module fabric_traffic_counter
    import ftc_pkg::*;
#(
    parameter int NUM_EV = 8,
    parameter int CLK_W  = 64
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_EV-1:0]             ev_hit,
    input  logic [NUM_EV-1:0][PORT_W-1:0] ev_port,
    input  logic                          reg_wr,
    input  logic [ADDR_W-1:0]             reg_addr,
    input  logic [REG_W-1:0]              reg_wdata,
    output logic [REG_W-1:0]              reg_rdata
);
    localparam int CNT_W = REG_W - CODE_W;

    typedef struct packed {
        logic [REG_W-1:0]  ctrl;
        logic [CODE_W-1:0] echo;
    } top_st_t;

    top_st_t st_d, st_q;

    sel_t              cur_sel;
    sel_t              new_sel;
    logic              ctrl_we;
    logic              sel_chg;
    logic              hit;
    logic [CNT_W-1:0]  cnt;
    logic [CLK_W-1:0]  cycles;
    logic [CODE_W-1:0] wr_code;

    assign cur_sel = decode_ctrl(st_q.ctrl);
    assign new_sel = decode_ctrl(reg_wdata);
    assign wr_code = new_sel.code;
    assign ctrl_we = reg_wr && (reg_addr == ADDR_CTRL);
    assign sel_chg = ctrl_we && ((new_sel.code != cur_sel.code) ||
                                 (new_sel.filt != cur_sel.filt) ||
                                 (new_sel.pid  != cur_sel.pid));

    always_comb begin
        st_d      = st_q;
        st_d.echo = cur_sel.code;
        if (ctrl_we) st_d.ctrl = reg_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    ftc_event_match #(.NUM_EV(NUM_EV)) u_match (
        .clk     (clk),
        .rst_n   (rst_n),
        .ev_hit  (ev_hit),
        .ev_port (ev_port),
        .code    (cur_sel.code),
        .filt_en (cur_sel.filt),
        .pid     (cur_sel.pid),
        .hit     (hit)
    );

    ftc_count_core #(.CNT_W(CNT_W)) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (cur_sel.clr),
        .frz     (cur_sel.frz),
        .sel_chg (sel_chg),
        .hit     (hit),
        .cnt     (cnt)
    );

    ftc_cycle_counter #(.CLK_W(CLK_W)) u_cyc (
        .clk    (clk),
        .rst_n  (rst_n),
        .cycles (cycles)
    );

    always_comb begin
        case (reg_addr)
            ADDR_CTRL:  reg_rdata = st_q.ctrl;
            ADDR_COUNT: reg_rdata = {st_q.echo, cnt};
            ADDR_CYCLE: reg_rdata = REG_W'(cycles);
            default:    reg_rdata = '0;
        endcase
    end

    // R9: echo shows the written code two edges after the write edge
    a_r9_echo_lag: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_we |=> ##1 (st_q.echo == $past(wr_code, 2)));
    // R1: a control write is visible on the next cycle
    a_r1_ctrl_readback: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_we |=> (st_q.ctrl == $past(reg_wdata)));
endmodule

// File: tb/fabric_traffic_counter_tb.sv
module fabric_traffic_counter_tb_top;
    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [7:0]       ev_hit = '0;
    logic [7:0][1:0]  ev_port = '0;
    logic             reg_wr = 1'b0;
    logic [7:0]       reg_addr = '0;
    logic [63:0]      reg_wdata = '0;
    logic [63:0]      reg_rdata;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    fabric_traffic_counter dut_i (
        .clk(clk), .rst_n(rst_n), .ev_hit(ev_hit), .ev_port(ev_port),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] mk(input bit clr, input bit frz, input int code,
                                       input int pid, input bit filt);
        logic [63:0] v = '0;
        v[0] = clr; v[8] = frz; v[19:16] = 4'(code); v[21:20] = 2'(pid); v[23] = filt;
        return v;
    endfunction

    task automatic wr(input logic [7:0] a, input logic [63:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [63:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    // drive n cycles of pattern, return expected number of counted cycles
    task automatic drive(input int code, input bit filt, input int pid, input int n,
                         input int seed, input bit all_on, output int exp);
        exp = 0;
        for (int i = 0; i < n; i++) begin
            ev_hit = all_on ? 8'hFF : 8'((i * 73 + seed * 29) ^ (i << 2));
            for (int j = 0; j < 8; j++) ev_port[j] = 2'((i + j * 3 + seed) % 4);
            if (code < 8 && ev_hit[code] && (!filt || int'(ev_port[code]) == pid)) exp++;
            @(negedge clk);
        end
        ev_hit = '0;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [63:0] v, base, c0, c1;
        int exp;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 / R2 reset state, R11 unmapped
        rd(8'h20, v); chk("R1 ctrl after reset", v, 64'h0);
        rd(8'h28, v); chk("R2 count after reset", v, 64'h0);
        rd(8'h18, v); chk("R11 unmapped addr", v, 64'h0);
        rd(8'h31, v); chk("R11 unaligned addr", v, 64'h0);

        // R2 / R3 sweep of every code, filter off
        for (int c = 0; c < 8; c++) begin
            wr(8'h20, mk(0, 0, c, 3, 0));
            @(negedge clk);
            rd(8'h28, base);
            drive(c, 0, 0, 24, c, 0, exp);
            rd(8'h28, v);
            chk($sformatf("R3 unfiltered code %0d", c), {4'h0, v[59:0]},
                {4'h0, base[59:0]} + 64'(exp));
            chk($sformatf("R2 echo code %0d", c), 64'(v[63:60]), 64'(c));
        end

        // R4 filter on, every port, two codes
        for (int c = 0; c < 8; c += 5) begin
            for (int p = 0; p < 4; p++) begin
                wr(8'h20, mk(0, 0, c, p, 1));
                @(negedge clk);
                rd(8'h28, base);
                drive(c, 1, p, 24, p + c, 0, exp);
                rd(8'h28, v);
                chk($sformatf("R4 filtered code %0d port %0d", c, p), {4'h0, v[59:0]},
                    {4'h0, base[59:0]} + 64'(exp));
            end
        end

        // R5 invalid codes count nothing
        for (int c = 8; c < 16; c++) begin
            wr(8'h20, mk(0, 0, c, 0, 0));
            @(negedge clk);
            drive(c, 0, 0, 6, c, 1, exp);
            rd(8'h28, v);
            chk($sformatf("R5 invalid code %0d count", c), {4'h0, v[59:0]}, 64'h0);
            chk($sformatf("R5 invalid code %0d echo", c), 64'(v[63:60]), 64'(c));
        end

        // R8 reselection clears; R7 freeze holds; same-selection write keeps count
        wr(8'h20, mk(0, 0, 2, 0, 0));
        drive(2, 0, 0, 5, 0, 1, exp);
        rd(8'h28, v); chk("R3 all-on count 5", {4'h0, v[59:0]}, 64'd5);
        wr(8'h20, mk(0, 1, 2, 0, 0));
        rd(8'h28, v); chk("R8 same selection keeps count", {4'h0, v[59:0]}, 64'd5);
        drive(2, 0, 0, 6, 0, 1, exp);
        rd(8'h28, v); chk("R7 frozen count held", {4'h0, v[59:0]}, 64'd5);
        wr(8'h20, mk(0, 0, 2, 0, 0));
        drive(2, 0, 0, 3, 0, 1, exp);
        rd(8'h28, v); chk("R7 resumes after unfreeze", {4'h0, v[59:0]}, 64'd8);
        wr(8'h20, mk(0, 0, 2, 0, 1));
        rd(8'h28, v); chk("R8 filter toggle clears", {4'h0, v[59:0]}, 64'd0);
        drive(2, 0, 0, 4, 0, 1, exp);
        wr(8'h20, mk(0, 0, 2, 1, 1));
        rd(8'h28, v); chk("R8 port change clears", {4'h0, v[59:0]}, 64'd0);
        wr(8'h20, mk(0, 0, 2, 0, 0));
        drive(2, 0, 0, 4, 0, 1, exp);
        rd(8'h28, v); chk("R3 count before clear", {4'h0, v[59:0]}, 64'd4);

        // R6 clear beats freeze; R10 cycle counter unaffected
        rd(8'h30, c0);
        wr(8'h20, mk(1, 1, 2, 0, 0));
        @(negedge clk);
        rd(8'h28, v); chk("R6 clear with freeze", {4'h0, v[59:0]}, 64'd0);
        drive(2, 0, 0, 5, 0, 1, exp);
        rd(8'h28, v); chk("R6 clear held under strobes", {4'h0, v[59:0]}, 64'd0);
        rd(8'h30, c1); chk("R10 cycles during clear/freeze", c1 - c0, 64'd8);
        wr(8'h20, mk(0, 1, 2, 0, 0));
        drive(2, 0, 0, 3, 0, 1, exp);
        rd(8'h28, v); chk("R7 frozen after clear released", {4'h0, v[59:0]}, 64'd0);
        wr(8'h20, mk(0, 0, 2, 0, 0));
        drive(2, 0, 0, 3, 0, 1, exp);
        rd(8'h28, v); chk("R3 counts after release", {4'h0, v[59:0]}, 64'd3);

        // R9 echo lag
        wr(8'h20, mk(0, 0, 6, 0, 0));
        @(negedge clk);
        wr(8'h20, mk(0, 0, 3, 0, 0));
        rd(8'h28, v); chk("R9 echo still old", 64'(v[63:60]), 64'd6);
        @(negedge clk);
        rd(8'h28, v); chk("R9 echo updated", 64'(v[63:60]), 64'd3);

        // R1 exact readback including unused bits
        wr(8'h20, 64'hA5C3_0F0F_FF7A_5EFE);
        rd(8'h20, v); chk("R1 exact readback", v, 64'hA5C3_0F0F_FF7A_5EFE);

        // R10 plain interval
        rd(8'h30, c0);
        repeat (37) @(negedge clk);
        rd(8'h30, c1); chk("R10 cycle interval", c1 - c0, 64'd37);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule